// File: doc/BRIEF.md
# Single-cycle processor main control decoder

This block turns the opcode and function fields of a 32-bit instruction into the full set of datapath control signals for a single-cycle processor. The opcode is the top six bits of the word, [31:26], and the function code is the bottom six bits, [5:0]. Opcode 0 marks the register-to-register format, where the function code picks the operation. Every other opcode selects an immediate-operand, memory, branch or jump operation on its own.

Each control output is a boolean expression over a small set of per-instruction match terms. The decode does not use one large table. The outputs come from a register stage with a synchronous active-high reset, so the controls for an instruction appear one clock after it is presented.

Two instructions copy the next-instruction address into a register. These are the absolute jump-and-link and the register jump-and-link. Both raise one shared `link_o` signal. The datapath sends the return address through the ALU as an add with zero and writes the result back. The absolute form forces register 31 as the destination. The register form writes to the rd field [15:11]. The plain register jump and the register jump-and-link share `reg_jump_o`, which takes the target address from the register named by rs [25:21].

Top module: `ctrl_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 after that edge.
- R2: The outputs after a rising edge decode the `op_i`/`fn_i` values sampled at that edge, with one cycle of latency. `alu_cls_o` uses these codes: 0 = add, 1 = subtract/compare, 2 = operation from the function code, 3 = operation from the opcode.
- R3: With opcode 0 and a function code other than 0x08 or 0x09, the outputs are `dst_rd_o`=1, `reg_we_o`=1 and `alu_cls_o`=2, with all other outputs 0.
- R4: Opcode 0 with function 0x08 (register jump) gives `reg_jump_o`=1 and `jump_o`=1, with all other outputs 0. There is no register write and no memory write.
- R5: Opcode 0 with function 0x09 (register jump-and-link) gives `link_o`, `reg_jump_o`, `jump_o`, `reg_we_o` and `dst_rd_o` all 1 and `alu_cls_o`=0, with all other outputs 0.
- R6: Opcode 0x03 (jump-and-link) gives `link_o`, `jump_o` and `reg_we_o` all 1, with `dst_rd_o`=0, `reg_jump_o`=0 and `alu_cls_o`=0. The link selects register 31.
- R7: Opcode 0x02 (jump) gives `jump_o`=1, with all other outputs 0.
- R8: Opcode 0x23 (load word) gives `mem_rd_o`, `wb_mem_o`, `reg_we_o`, `src_imm_o` and `sext_o` all 1 and `alu_cls_o`=0, with all other outputs 0.
- R9: Opcode 0x2B (store word) gives `mem_wr_o`, `src_imm_o` and `sext_o` all 1 and `alu_cls_o`=0, with all other outputs 0.
- R10: Opcodes 0x04 and 0x05 (branch on equal or not equal) give `branch_o`=1, `sext_o`=1 and `alu_cls_o`=1, with all other outputs 0.
- R11: Opcodes 0x08 to 0x0B (arithmetic immediates) give `reg_we_o`, `src_imm_o` and `sext_o` all 1 and `alu_cls_o`=3, with all other outputs 0. For any opcode other than 0, the function code has no effect.
- R12: Opcodes 0x0C to 0x0F (logical immediates and load-upper) give `reg_we_o`=1, `src_imm_o`=1 and `alu_cls_o`=3, with `sext_o`=0 and all other outputs 0.
- R13: Any other opcode drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 6 | Opcode field, instruction bits [31:26] |
| fn_i | input | 6 | Function field, instruction bits [5:0] |
| dst_rd_o | output | 1 | Destination from rd (1) or rt (0) |
| link_o | output | 1 | Write the return address, routed through the ALU as an add with zero |
| reg_jump_o | output | 1 | Jump target taken from register rs |
| jump_o | output | 1 | Unconditional jump |
| reg_we_o | output | 1 | Register file write enable |
| src_imm_o | output | 1 | ALU second operand is the immediate |
| alu_cls_o | output | 2 | ALU operation class (0 add, 1 subtract, 2 from function code, 3 from opcode) |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| wb_mem_o | output | 1 | Write-back value from memory |
| branch_o | output | 1 | Conditional branch |
| sext_o | output | 1 | Sign-extend the immediate (0 = zero-extend) |

## Verification
The assertions assume that `op_i` and `fn_i` carry known values at every rising edge after reset. They also assume the outputs are compared against the opcode sampled one edge earlier. Assertions that depend on that earlier opcode are turned off in the cycle right after reset, because the outputs still show the cleared state then. The stimulus keeps within these limits. It changes inputs only on falling edges and drives a defined value in every cycle, including during reset. It covers all 64 opcodes, several function codes under opcode 0, and non-zero opcodes paired with the jump function codes. It also applies reset in the middle of the stream with a valid instruction present.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

  localparam int OP_W = 6;
  localparam int FN_W = 6;

  localparam logic [OP_W-1:0] OP_RFMT  = 6'h00;
  localparam logic [OP_W-1:0] OP_JMP   = 6'h02;
  localparam logic [OP_W-1:0] OP_JLNK  = 6'h03;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_BNE   = 6'h05;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OP_ARI_LO = 6'h08;
  localparam logic [OP_W-1:0] OP_ARI_HI = 6'h0B;
  localparam logic [OP_W-1:0] OP_BOOL_LO = 6'h0C;
  localparam logic [OP_W-1:0] OP_BOOL_HI = 6'h0F;

  localparam logic [FN_W-1:0] FN_RJMP  = 6'h08;
  localparam logic [FN_W-1:0] FN_RJLNK = 6'h09;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'd0,
    ALU_SUB   = 2'd1,
    ALU_FUNCT = 2'd2,
    ALU_IMMOP = 2'd3
  } alu_cls_e;

  typedef struct packed {
    logic     dst_rd;
    logic     link;
    logic     reg_jump;
    logic     jump;
    logic     reg_we;
    logic     src_imm;
    alu_cls_e alu_cls;
    logic     mem_rd;
    logic     mem_wr;
    logic     wb_mem;
    logic     branch;
    logic     sext;
  } ctrl_t;

  typedef struct packed {
    logic alu_r;
    logic rjmp;
    logic rjlnk;
    logic jmp;
    logic jlnk;
    logic brn;
    logic load;
    logic store;
    logic ari_i;
    logic bool_i;
  } hit_t;

endpackage

// File: rtl/ctrl_match.sv
module ctrl_match
  import ctrl_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int FNW = FN_W
) (
  input  logic [OPW-1:0] op,
  input  logic [FNW-1:0] fn,
  output hit_t           hit
);
  logic is_rfmt;
  logic fn_rjmp;
  logic fn_rjlnk;

  assign is_rfmt  = (op == OPW'(OP_RFMT));
  assign fn_rjmp  = (fn == FNW'(FN_RJMP));
  assign fn_rjlnk = (fn == FNW'(FN_RJLNK));

  always_comb begin
    hit        = '0;
    hit.rjmp   = is_rfmt & fn_rjmp;
    hit.rjlnk  = is_rfmt & fn_rjlnk;
    hit.alu_r  = is_rfmt & ~fn_rjmp & ~fn_rjlnk;
    hit.jmp    = (op == OPW'(OP_JMP));
    hit.jlnk   = (op == OPW'(OP_JLNK));
    hit.brn    = (op == OPW'(OP_BEQ)) | (op == OPW'(OP_BNE));
    hit.load   = (op == OPW'(OP_LOAD));
    hit.store  = (op == OPW'(OP_STORE));
    hit.ari_i  = (op >= OPW'(OP_ARI_LO)) & (op <= OPW'(OP_ARI_HI));
    hit.bool_i = (op >= OPW'(OP_BOOL_LO)) & (op <= OPW'(OP_BOOL_HI));
  end

  always_comb begin
    a_onehot_r13: assert ($onehot0(hit));
  end
endmodule

// File: rtl/ctrl_terms.sv
module ctrl_terms
  import ctrl_pkg::*;
(
  input  hit_t  hit,
  output ctrl_t ctl
);
  logic any_link;
  logic imm_alu;
  logic mem_acc;

  assign any_link = hit.jlnk | hit.rjlnk;
  assign imm_alu  = hit.ari_i | hit.bool_i;
  assign mem_acc  = hit.load | hit.store;

  always_comb begin
    ctl          = '0;
    ctl.dst_rd   = hit.alu_r | hit.rjlnk;
    ctl.link     = any_link;
    ctl.reg_jump = hit.rjmp | hit.rjlnk;
    ctl.jump     = hit.jmp | hit.rjmp | any_link;
    ctl.reg_we   = hit.alu_r | any_link | hit.load | imm_alu;
    ctl.src_imm  = mem_acc | imm_alu;
    ctl.mem_rd   = hit.load;
    ctl.mem_wr   = hit.store;
    ctl.wb_mem   = hit.load;
    ctl.branch   = hit.brn;
    ctl.sext     = hit.ari_i | mem_acc | hit.brn;
    if (hit.alu_r)      ctl.alu_cls = ALU_FUNCT;
    else if (imm_alu)   ctl.alu_cls = ALU_IMMOP;
    else if (hit.brn)   ctl.alu_cls = ALU_SUB;
    else                ctl.alu_cls = ALU_ADD;
  end
endmodule

// File: rtl/ctrl_pipe.sv
module ctrl_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int FNW = FN_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_i,
  input  logic [FNW-1:0] fn_i,
  output logic           dst_rd_o,
  output logic           link_o,
  output logic           reg_jump_o,
  output logic           jump_o,
  output logic           reg_we_o,
  output logic           src_imm_o,
  output logic [1:0]     alu_cls_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic           wb_mem_o,
  output logic           branch_o,
  output logic           sext_o
);
  localparam int CW = $bits(ctrl_t);

  hit_t          hit;
  ctrl_t         ctl_d;
  ctrl_t         ctl_q;
  logic [CW-1:0] q_vec;

  ctrl_match #(.OPW(OPW), .FNW(FNW)) u_match (.op(op_i), .fn(fn_i), .hit(hit));
  ctrl_terms u_terms (.hit(hit), .ctl(ctl_d));
  ctrl_pipe #(.W(CW)) u_pipe (.clk(clk), .rst(rst), .d(ctl_d), .q(q_vec));

  assign ctl_q      = ctrl_t'(q_vec);
  assign dst_rd_o   = ctl_q.dst_rd;
  assign link_o     = ctl_q.link;
  assign reg_jump_o = ctl_q.reg_jump;
  assign jump_o     = ctl_q.jump;
  assign reg_we_o   = ctl_q.reg_we;
  assign src_imm_o  = ctl_q.src_imm;
  assign alu_cls_o  = ctl_q.alu_cls;
  assign mem_rd_o   = ctl_q.mem_rd;
  assign mem_wr_o   = ctl_q.mem_wr;
  assign wb_mem_o   = ctl_q.wb_mem;
  assign branch_o   = ctl_q.branch;
  assign sext_o     = ctl_q.sext;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (q_vec == '0));

  p_store_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op_i) == OPW'(OP_STORE)) |-> (mem_wr_o && !reg_we_o));

  p_rjmp_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_jump_o && !link_o) |-> (!reg_we_o && !mem_wr_o && jump_o));

  p_link_writes_r5: assert property (@(posedge clk) disable iff (rst)
    link_o |-> (reg_we_o && jump_o && alu_cls_o == 2'd0));

  p_abs_link_r31_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op_i) == OPW'(OP_JLNK)) |-> (link_o && !dst_rd_o && !reg_jump_o));

  p_mem_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  p_bool_zext_r12: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op_i) >= OPW'(OP_BOOL_LO) && $past(op_i) <= OPW'(OP_BOOL_HI))
      |-> (!sext_o && src_imm_o));
endmodule

// File: tb/ctrl_decoder_tb.sv
module ctrl_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] op_i = '0;
  logic [5:0] fn_i = '0;
  logic dst_rd_o, link_o, reg_jump_o, jump_o, reg_we_o, src_imm_o;
  logic [1:0] alu_cls_o;
  logic mem_rd_o, mem_wr_o, wb_mem_o, branch_o, sext_o;

  always #4 clk = ~clk;

  ctrl_decoder u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .fn_i(fn_i),
    .dst_rd_o(dst_rd_o), .link_o(link_o), .reg_jump_o(reg_jump_o),
    .jump_o(jump_o), .reg_we_o(reg_we_o), .src_imm_o(src_imm_o),
    .alu_cls_o(alu_cls_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .wb_mem_o(wb_mem_o), .branch_o(branch_o), .sext_o(sext_o)
  );

  typedef struct {
    logic [12:0] bits;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // packing: dst_rd link reg_jump jump reg_we src_imm alu[1:0] mem_rd mem_wr wb_mem branch sext
  function automatic exp_t model(input logic r, input logic [5:0] op, input logic [5:0] fn);
    exp_t e;
    e.bits = '0;
    if (r) begin e.tag = "R1"; return e; end
    case (op)
      6'h00: begin
        if (fn == 6'h08)      begin e.bits = 13'b0011000000000; e.tag = "R4"; end
        else if (fn == 6'h09) begin e.bits = 13'b1111100000000; e.tag = "R5"; end
        else                  begin e.bits = 13'b1000101000000; e.tag = "R3"; end
      end
      6'h03: begin e.bits = 13'b0101100000000; e.tag = "R6"; end
      6'h02: begin e.bits = 13'b0001000000000; e.tag = "R7"; end
      6'h23: begin e.bits = 13'b0000110010101; e.tag = "R8"; end
      6'h2B: begin e.bits = 13'b0000010001001; e.tag = "R9"; end
      6'h04, 6'h05: begin e.bits = 13'b0000000100011; e.tag = "R10"; end
      6'h08, 6'h09, 6'h0A, 6'h0B: begin e.bits = 13'b0000111100001; e.tag = "R11"; end
      6'h0C, 6'h0D, 6'h0E, 6'h0F: begin e.bits = 13'b0000111100000; e.tag = "R12"; end
      default: e.tag = "R13";
    endcase
    return e;
  endfunction

  task automatic drive(input logic r, input logic [5:0] op, input logic [5:0] fn);
    @(negedge clk);
    rst  = r;
    op_i = op;
    fn_i = fn;
    q.push_back(model(r, op, fn));
  endtask

  // monitor: outputs registered at posedge after the drive; sample 1 ns later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        logic [12:0] act;
        e   = q.pop_front();
        act = {dst_rd_o, link_o, reg_jump_o, jump_o, reg_we_o, src_imm_o, alu_cls_o,
               mem_rd_o, mem_wr_o, wb_mem_o, branch_o, sext_o};
        n_cmp++;
        if (act !== e.bits) begin
          n_bad++;
          $display("FAIL %s (R2 timing) actual=%b expected=%b", e.tag, act, e.bits);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    drive(1'b1, 6'h23, 6'h00);            // R1 reset with load present
    drive(1'b1, 6'h00, 6'h09);            // R1
    drive(1'b0, 6'h00, 6'h20);            // R3 add
    drive(1'b0, 6'h00, 6'h22);            // R3 sub
    drive(1'b0, 6'h00, 6'h2A);            // R3 slt
    drive(1'b0, 6'h00, 6'h00);            // R3 shift
    drive(1'b0, 6'h00, 6'h08);            // R4
    drive(1'b0, 6'h00, 6'h09);            // R5
    drive(1'b0, 6'h00, 6'h0A);            // R3 neighbour of R5 code
    drive(1'b0, 6'h03, 6'h00);            // R6
    drive(1'b0, 6'h02, 6'h00);            // R7
    drive(1'b0, 6'h23, 6'h09);            // R8 funct ignored
    drive(1'b0, 6'h2B, 6'h08);            // R9
    drive(1'b0, 6'h04, 6'h00);            // R10
    drive(1'b0, 6'h05, 6'h3F);            // R10
    drive(1'b0, 6'h08, 6'h08);            // R11 funct 0x08 ignored
    drive(1'b0, 6'h0B, 6'h09);            // R11
    drive(1'b0, 6'h0C, 6'h00);            // R12
    drive(1'b0, 6'h0F, 6'h09);            // R12
    drive(1'b0, 6'h01, 6'h08);            // R13
    drive(1'b0, 6'h3F, 6'h09);            // R13
    drive(1'b0, 6'h03, 6'h09);            // R6 then reset mid-stream
    drive(1'b1, 6'h03, 6'h09);            // R1
    drive(1'b0, 6'h00, 6'h09);            // R5 right after reset
    for (int o = 0; o < 64; o++) begin
      drive(1'b0, 6'(o), 6'(o));          // sweep all opcodes, R2..R13
      drive(1'b0, 6'(o), 6'h08);
    end
    drive(1'b0, 6'h00, 6'h25);
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule